// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Data Cache

This block sits beside a direct-mapped first-level data cache and keeps a handful of whole lines that the cache recently threw out. When the cache misses, the block address of the request is compared against every stored line at once. On a match the stored line is handed back to the cache in the same cycle. If the cache is evicting a line in that same cycle, the evicted line takes the matching slot, so the two lines trade places. When nothing matches, the request is passed on to the next memory level. Lines that the cache discards are captured here.

Slots are fully associative. An incoming line goes to the lowest empty slot. When every slot is occupied, a rotating replacement pointer picks the slot to overwrite. A displaced line that was modified is sent out on a writeback port in the cycle it is displaced. A displaced clean line is simply dropped. Lookup, the hit line, the forward request and the writeback are all combinational outputs for the current cycle. The stored state changes on the next rising clock edge.

Top module: `victim_cache`

## Requirements
- R1: A synchronous active-high reset leaves every slot empty, so the first request after reset misses and is forwarded.
- R2: When a request block address equals the block of a valid slot, `hit` is 1 in that same cycle. In that cycle `hit_data` and `hit_dirty` carry the stored line and its modified flag.
- R3: When a request matches no valid slot, `hit` is 0 and `fwd_valid` is 1 in that same cycle, with `fwd_blk` equal to request address bits 31..5.
- R4: A hit in a cycle with `evict_valid` high stores the evicted block, data and dirty flag into the slot that hit, and the other slots are unchanged. Afterwards the evicted block hits and the old block misses.
- R5: A hit with `evict_valid` low empties the slot that hit, and the returned block misses from then on.
- R6: An eviction that is not paired with a hit fills the lowest-numbered empty slot when one exists. It raises no writeback and does not move the replacement pointer.
- R7: When all slots are valid, an eviction not paired with a hit overwrites the slot at the replacement pointer. The pointer is 0 after reset and advances by one, modulo the slot count, after each such overwrite.
- R8: When R7 overwrites a slot whose dirty flag is 1, `wb_valid` is 1 in that cycle, with `wb_blk` and `wb_data` equal to the displaced line. In every other cycle `wb_valid` is 0.
- R9: Request address bits 4..0 (the byte offset within the 32-byte line) take no part in the comparison.
- R10: With `req_valid` and `evict_valid` both low, the stored state does not change, and `hit`, `fwd_valid` and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | First-level cache miss lookup request |
| req_addr | input | 32 | Byte address of the missing access |
| evict_valid | input | 1 | First-level cache is discarding a line this cycle |
| evict_blk | input | 27 | Block address of the discarded line |
| evict_data | input | 256 | Contents of the discarded line |
| evict_dirty | input | 1 | Discarded line was modified |
| hit | output | 1 | Request found in a slot |
| hit_data | output | 256 | Line returned on a hit |
| hit_dirty | output | 1 | Modified flag of the returned line |
| fwd_valid | output | 1 | Request passed to the next memory level |
| fwd_blk | output | 27 | Block address passed on |
| wb_valid | output | 1 | Modified line displaced this cycle |
| wb_blk | output | 27 | Block address of the displaced line |
| wb_data | output | 256 | Contents of the displaced line |

## Verification
The bench builds the block with its defaults: four slots, 32-bit addresses and 32-byte lines. With only four slots, a few evictions fill the buffer. The directed part then walks the replacement pointer all the way round, and a random phase that draws blocks from a pool of twelve produces frequent swaps, take-backs, full-buffer overwrites and writebacks of modified lines. The random phase uses a random byte offset on every request, which exercises the offset-blind match.

// File: rtl/vc_pkg.sv
package vc_pkg;

    // Per-cycle action applied to the slot array
    typedef enum logic [1:0] {
        VC_NONE = 2'd0,   // nothing stored changes
        VC_SWAP = 2'd1,   // hit slot receives the evicted line
        VC_TAKE = 2'd2,   // hit slot is handed back and emptied
        VC_FILL = 2'd3    // evicted line written to an allocated slot
    } vc_op_e;

    // Index of the lowest set bit of a mask, 0 when the mask is empty
    function automatic int unsigned vc_lowest(input logic [31:0] mask);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (mask[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/vc_match.sv
module vc_match #(
    parameter int N  = 4,
    parameter int BW = 27
) (
    input  logic [N-1:0]  valid,
    input  logic [BW-1:0] tags [N],
    input  logic [BW-1:0] key,
    input  logic          en,
    output logic [N-1:0]  match
);
    // One comparator per slot, all evaluated together
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = en && valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  valid,
    input  logic          fill,
    output logic [IW-1:0] slot,
    output logic          full
);
    import vc_pkg::*;

    logic [IW-1:0] ptr_q;
    logic [31:0]   free_mask;

    always_comb begin
        free_mask = '0;
        free_mask[N-1:0] = ~valid;
    end

    assign full = &valid;
    assign slot = full ? ptr_q : IW'(vc_lowest(free_mask));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (fill && full) begin
            ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(fill && full) |=> $stable(ptr_q));

    // R6
    free_pick_chk: assert property (@(posedge clk) disable iff (rst)
        !full |-> !valid[slot]);
endmodule

// File: rtl/vc_store.sv
module vc_store #(
    parameter int N  = 4,
    parameter int BW = 27,
    parameter int LW = 256,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  vc_pkg::vc_op_e   op,
    input  logic [IW-1:0]    idx,
    input  logic [BW-1:0]    wr_blk,
    input  logic [LW-1:0]    wr_data,
    input  logic             wr_dirty,
    output logic [N-1:0]     valid,
    output logic [N-1:0]     dirty,
    output logic [BW-1:0]    blk  [N],
    output logic [LW-1:0]    data [N]
);
    import vc_pkg::*;

    logic wr_en;
    assign wr_en = (op == VC_SWAP) || (op == VC_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            dirty <= '0;
        end else if (wr_en) begin
            valid[idx] <= 1'b1;
            dirty[idx] <= wr_dirty;
        end else if (op == VC_TAKE) begin
            valid[idx] <= 1'b0;
            dirty[idx] <= 1'b0;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (wr_en && idx == IW'(g)) begin
                blk[g]  <= wr_blk;
                data[g] <= wr_data;
            end
        end
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> valid == '0);

    // R4
    write_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid[$past(idx)]);

    // R5
    take_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (op == VC_TAKE) |=> !valid[$past(idx)]);
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int ENTRIES    = 4,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int BW    = ADDR_W - OFF_W,
    localparam int LW    = LINE_BYTES * 8,
    localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              evict_valid,
    input  logic [BW-1:0]     evict_blk,
    input  logic [LW-1:0]     evict_data,
    input  logic              evict_dirty,
    output logic              hit,
    output logic [LW-1:0]     hit_data,
    output logic              hit_dirty,
    output logic              fwd_valid,
    output logic [BW-1:0]     fwd_blk,
    output logic              wb_valid,
    output logic [BW-1:0]     wb_blk,
    output logic [LW-1:0]     wb_data
);
    import vc_pkg::*;

    logic [ENTRIES-1:0] valid, dirty, match;
    logic [BW-1:0]      blk  [ENTRIES];
    logic [LW-1:0]      data [ENTRIES];
    logic [BW-1:0]      req_blk;
    logic [IW-1:0]      hit_idx, alloc_slot, wr_idx;
    logic               full;
    vc_op_e             op;

    assign req_blk = req_addr[ADDR_W-1:OFF_W];

    vc_match #(.N(ENTRIES), .BW(BW)) u_match (
        .valid(valid), .tags(blk), .key(req_blk), .en(req_valid), .match(match)
    );

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = IW'(i);
        end
    end

    assign hit       = |match;
    assign hit_data  = data[hit_idx];
    assign hit_dirty = dirty[hit_idx];
    assign fwd_valid = req_valid && !hit;
    assign fwd_blk   = req_blk;

    always_comb begin
        if (hit)              op = evict_valid ? VC_SWAP : VC_TAKE;
        else if (evict_valid) op = VC_FILL;
        else                  op = VC_NONE;
    end

    vc_alloc #(.N(ENTRIES)) u_alloc (
        .clk(clk), .rst(rst), .valid(valid), .fill(op == VC_FILL),
        .slot(alloc_slot), .full(full)
    );

    assign wr_idx = hit ? hit_idx : alloc_slot;

    assign wb_valid = (op == VC_FILL) && full && dirty[alloc_slot];
    assign wb_blk   = blk[alloc_slot];
    assign wb_data  = data[alloc_slot];

    vc_store #(.N(ENTRIES), .BW(BW), .LW(LW)) u_store (
        .clk(clk), .rst(rst), .op(op), .idx(wr_idx),
        .wr_blk(evict_blk), .wr_data(evict_data), .wr_dirty(evict_dirty),
        .valid(valid), .dirty(dirty), .blk(blk), .data(data)
    );

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R8
    wb_only_on_fill_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (evict_valid && !hit && full));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !evict_valid) |=> $stable(valid) && $stable(dirty));
endmodule

// File: tb/test_victim_cache.sv
module test_victim_cache;
    localparam int N  = 4;
    localparam int BW = 27;
    localparam int LW = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic          evict_valid = 1'b0;
    logic [BW-1:0] evict_blk = '0;
    logic [LW-1:0] evict_data = '0;
    logic          evict_dirty = 1'b0;
    logic          hit, hit_dirty, fwd_valid, wb_valid;
    logic [LW-1:0] hit_data, wb_data;
    logic [BW-1:0] fwd_blk, wb_blk;

    victim_cache i_victim_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .evict_valid(evict_valid), .evict_blk(evict_blk), .evict_data(evict_data),
        .evict_dirty(evict_dirty), .hit(hit), .hit_data(hit_data), .hit_dirty(hit_dirty),
        .fwd_valid(fwd_valid), .fwd_blk(fwd_blk), .wb_valid(wb_valid),
        .wb_blk(wb_blk), .wb_data(wb_data)
    );

    always #10 clk = ~clk;   // 50 MHz

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Behavioural reference state
    bit            m_v [N];
    bit            m_d [N];
    logic [BW-1:0] m_b [N];
    logic [LW-1:0] m_l [N];
    int            m_p = 0;

    function automatic logic [LW-1:0] pat(input logic [BW-1:0] b, input int salt);
        return {8{32'(b) ^ 32'(salt * 32'h01010101) ^ 32'h5a5a0000}};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit present(input logic [BW-1:0] b);
        for (int i = 0; i < N; i++) if (m_v[i] && m_b[i] == b) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(input bit rq, input logic [31:0] addr, input bit ev,
                        input logic [BW-1:0] eb, input bit ed, input int salt,
                        input string tag);
        int h, slot;
        bit e_wb;
        logic [BW-1:0] e_wbb;
        logic [LW-1:0] e_wbd;
        @(negedge clk);
        req_valid = rq; req_addr = addr;
        evict_valid = ev; evict_blk = eb; evict_data = pat(eb, salt); evict_dirty = ed;
        #2;
        h = -1;
        for (int i = 0; i < N; i++)
            if (rq && m_v[i] && m_b[i] == addr[31:5]) h = i;
        e_wb = 1'b0; e_wbb = '0; e_wbd = '0; slot = -1;
        if (h < 0 && ev) begin
            for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_p;
                e_wb = m_d[slot]; e_wbb = m_b[slot]; e_wbd = m_l[slot];
                m_p = (m_p + 1) % N;
            end
        end
        chk(hit == (h >= 0), {tag, " hit R2"}, LW'(hit), LW'(h >= 0));
        chk(fwd_valid == (rq && h < 0), {tag, " fwd_valid R3"}, LW'(fwd_valid), LW'(rq && h < 0));
        if (rq && h < 0) chk(fwd_blk == addr[31:5], {tag, " fwd_blk R3"}, LW'(fwd_blk), LW'(addr[31:5]));
        if (h >= 0) begin
            chk(hit_data == m_l[h], {tag, " hit_data R2"}, hit_data, m_l[h]);
            chk(hit_dirty == m_d[h], {tag, " hit_dirty R2"}, LW'(hit_dirty), LW'(m_d[h]));
        end
        chk(wb_valid == e_wb, {tag, " wb_valid R8"}, LW'(wb_valid), LW'(e_wb));
        if (e_wb) begin
            chk(wb_blk == e_wbb, {tag, " wb_blk R7"}, LW'(wb_blk), LW'(e_wbb));
            chk(wb_data == e_wbd, {tag, " wb_data R8"}, wb_data, e_wbd);
        end
        if (h >= 0) begin
            if (ev) begin
                m_b[h] = eb; m_l[h] = pat(eb, salt); m_d[h] = ed;
            end else begin
                m_v[h] = 1'b0; m_d[h] = 1'b0;
            end
        end else if (ev) begin
            m_v[slot] = 1'b1; m_d[slot] = ed; m_b[slot] = eb; m_l[slot] = pat(eb, salt);
        end
    endtask

    function automatic logic [31:0] ad(input logic [BW-1:0] b, input logic [4:0] off);
        return {b, off};
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; m_b[i] = '0; m_l[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: empty after reset, first request misses
        step(1, ad(27'h100, 5'd0), 0, '0, 0, 0, "R1 first lookup");
        // R10: idle cycle
        step(0, '0, 0, '0, 0, 0, "R10 idle");
        chk(fwd_valid == 0 && wb_valid == 0 && hit == 0, "R10 idle outputs", '0, '0);
        // R6: fill free slots in order 0,1,2
        step(0, '0, 1, 27'h0A0, 0, 1, "R6 fill A");
        step(0, '0, 1, 27'h0B0, 1, 1, "R6 fill B");
        step(0, '0, 1, 27'h0C0, 0, 1, "R6 fill C");
        // R9: offset ignored, R5: take-back without eviction
        step(1, ad(27'h0A0, 5'd7), 0, '0, 0, 0, "R9 R5 take A");
        step(1, ad(27'h0A0, 5'd31), 0, '0, 0, 0, "R5 A gone");
        // R6: freed slot 0 refilled, then slot 3
        step(0, '0, 1, 27'h0D0, 1, 2, "R6 fill D");
        step(0, '0, 1, 27'h0E0, 0, 2, "R6 fill E");
        // R4: swap B with F
        step(1, ad(27'h0B0, 5'd3), 1, 27'h0F0, 0, 3, "R4 swap B");
        step(1, ad(27'h0F0, 5'd0), 1, 27'h0B1, 1, 3, "R4 swap F");
        step(1, ad(27'h0B0, 5'd0), 0, '0, 0, 0, "R4 B absent");
        // R7 R8: full buffer, pointer wraps twice
        for (int k = 0; k < 2 * N + 1; k++)
            step(1, ad(27'h200 + 27'(k), 5'd1), 1, 27'h300 + 27'(k), k[0], 4, "R7 R8 overwrite");
        // Random mix
        for (int k = 0; k < 600; k++) begin
            logic [BW-1:0] rb, eb;
            bit rq, ev;
            rq = ($urandom % 4) != 0;
            ev = ($urandom % 3) != 0;
            rb = 27'h400 + 27'($urandom % 12);
            eb = 27'h400 + 27'($urandom % 12);
            if (ev && (present(eb) || (rq && eb == rb))) ev = 1'b0;
            step(rq, ad(rb, 5'($urandom)), ev, eb, bit'($urandom % 2), k, "RND");
        end
        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1; req_valid = 0; evict_valid = 0;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; end
        m_p = 0;
        step(1, ad(27'h300 + 27'(2 * N), 5'd0), 0, '0, 0, 0, "R1 after reset");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule